// File: doc/BRIEF.md
# Vector Butterfly Permutation Unit

This block moves 16-bit elements of a 128-element vector register by a power-of-two distance. The distance comes from a radix register, not from the command. Two commands exist. A left move copies the upper half of each butterfly pair toward lower indices. A right move copies the lower half toward higher indices. Used one after the other, these moves support tree reductions such as dot products and the element exchange in each stage of an FFT.

The unit streams the register through a 256-bit datapath, which carries 16 elements per beat. A full vector takes 8 beats.

- It reads source beats through a combinational read port and writes destination beats through a registered write port.
- All 8 destination beats are written in ascending order, one per cycle. Positions that receive no element are written as zero.
- For a radix of one beat or more, whole beats are routed unchanged.
- For a smaller radix, the data stays inside beat 0 and passes through a small in-beat shifter.
- A start/done handshake frames each command.
- A radix that is not a power of two in the range 1 to 64 is rejected with an error pulse, and nothing is written.

Top module: `bfly_perm_unit`

## Requirements
- R1: While reset is asserted and after it is released, wr_en_o, busy_o, done_o and err_o are low until a command is accepted.
- R2: With dir_i = 0 (left move) and radix r, destination element i equals source element i+r for every i < r. Element i lives in beat i/16, bits [16*(i%16)+15 : 16*(i%16)].
- R3: With dir_i = 1 (right move) and radix r, destination element i+r equals source element i for every i < r, using the same element layout as R2.
- R4: Every destination element not written by R2 or R3 is zero. This includes whole beats that receive no data.
- R5: An accepted valid command raises wr_en_o for exactly 8 consecutive cycles. The first write comes in the second cycle after the accepting edge, and wr_beat_o steps 0,1,...,7.
- R6: done_o is a single-cycle pulse in the cycle after the beat-7 write cycle. busy_o is high from the cycle after acceptance through the beat-7 write cycle, and low when done_o is high.
- R7: A radix that is not one of 1,2,4,8,16,32,64 produces done_o and err_o together for one cycle, in the cycle after acceptance, with no write and no busy cycle. err_o stays low for valid commands.
- R8: start_i is ignored while busy_o is high. No second command starts, and no extra write follows done_o.
- R9: radix_i and dir_i are captured when a command is accepted. Changes to them during the command do not affect the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Command request, accepted when idle |
| dir_i | input | 1 | 0 = left move, 1 = right move |
| radix_i | input | 8 | Butterfly distance in elements |
| rd_beat_o | output | 3 | Source beat index for the read port |
| rd_data_i | input | 256 | Source beat data, valid in the same cycle as rd_beat_o |
| wr_en_o | output | 1 | Destination write strobe |
| wr_beat_o | output | 3 | Destination beat index |
| wr_data_o | output | 256 | Destination beat data |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command finished (one cycle) |
| err_o | output | 1 | Radix rejected (one cycle, with done_o) |

## Verification
The hardest situation to reach from the ports is a command whose inputs change while it runs. The bench holds start_i high through the whole busy window and, in the same cycles, flips dir_i and puts an invalid radix on radix_i. The written beats must then still match the radix and direction that were captured, and no second command may follow done_o. The sub-beat radices are swept as well, because for them only beat 0 carries data and all other beats must be written as zero. Rejected radices on both sides of the valid set (0, 3, 96, 128, 255) are also covered.

// File: rtl/bfly_pkg.sv
package bfly_pkg;
  typedef enum logic [2:0] {
    CASE_L_SUB,
    CASE_R_SUB,
    CASE_L_ONE,
    CASE_R_ONE,
    CASE_L_MULTI,
    CASE_R_MULTI
  } bfly_case_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_LAST
  } bfly_state_e;
endpackage

// File: rtl/bfly_decode.sv
module bfly_decode
  import bfly_pkg::*;
#(
  parameter int unsigned NUM_ELEM   = 128,
  parameter int unsigned BEAT_ELEMS = 16,
  localparam int unsigned RADIX_W   = $clog2(NUM_ELEM) + 1,
  localparam int unsigned LG_W      = $clog2(NUM_ELEM),
  localparam int unsigned BEAT_LG   = $clog2(BEAT_ELEMS)
)(
  input  logic [RADIX_W-1:0] radix_i,
  input  logic               dir_i,
  output logic               ok_o,
  output bfly_case_e         case_o,
  output logic [LG_W-1:0]    lg_o
);
  always_comb begin
    ok_o = 1'b0;
    lg_o = '0;
    // legal radices: 2^0 .. 2^(LG_W-1)
    for (int i = 0; i < LG_W; i++) begin
      if (radix_i == RADIX_W'(RADIX_W'(1) << i)) begin
        ok_o = 1'b1;
        lg_o = LG_W'(i);
      end
    end
    if (lg_o < LG_W'(BEAT_LG))       case_o = dir_i ? CASE_R_SUB   : CASE_L_SUB;
    else if (lg_o == LG_W'(BEAT_LG)) case_o = dir_i ? CASE_R_ONE   : CASE_L_ONE;
    else                             case_o = dir_i ? CASE_R_MULTI : CASE_L_MULTI;
  end
endmodule

// File: rtl/bfly_seq.sv
module bfly_seq
  import bfly_pkg::*;
#(
  parameter int unsigned NUM_BEATS = 8,
  localparam int unsigned BEAT_AW  = $clog2(NUM_BEATS)
)(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               ok_i,
  output logic               busy_o,
  output logic               run_o,
  output logic [BEAT_AW-1:0] cnt_o,
  output logic               done_o,
  output logic               err_o
);
  localparam logic [BEAT_AW-1:0] LAST_BEAT = BEAT_AW'(NUM_BEATS - 1);

  bfly_state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_o   <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (ok_i) begin
              state_q <= ST_RUN;
              cnt_o   <= '0;
            end else begin
              done_o <= 1'b1;
              err_o  <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (cnt_o == LAST_BEAT) state_q <= ST_LAST;
          else                    cnt_o   <= cnt_o + BEAT_AW'(1);
        end
        ST_LAST: begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign run_o  = (state_q == ST_RUN);
endmodule

// File: rtl/bfly_lane_shift.sv
module bfly_lane_shift #(
  parameter int unsigned ELEM_W     = 16,
  parameter int unsigned BEAT_ELEMS = 16,
  localparam int unsigned DP_W      = ELEM_W * BEAT_ELEMS,
  localparam int unsigned BEAT_LG   = $clog2(BEAT_ELEMS)
)(
  input  logic [DP_W-1:0]    data_i,
  input  logic               left_i,
  input  logic [BEAT_LG-1:0] lg_i,
  output logic [DP_W-1:0]    data_o
);
  logic [DP_W-1:0]    stg [BEAT_LG+1];
  logic [BEAT_LG:0]   r_amt;
  logic [BEAT_LG:0]   r_end;

  assign stg[0] = data_i;
  assign r_amt  = (BEAT_LG+1)'(1) << lg_i;
  assign r_end  = r_amt << 1;

  // one stage per power of two; only the stage matching the radix is active
  for (genvar s = 0; s < BEAT_LG; s++) begin : g_stg
    localparam int unsigned SH = ELEM_W * (1 << s);
    logic en;
    assign en = (lg_i == BEAT_LG'(s));
    assign stg[s+1] = !en ? stg[s] : (left_i ? (stg[s] >> SH) : (stg[s] << SH));
  end

  for (genvar k = 0; k < BEAT_ELEMS; k++) begin : g_msk
    localparam logic [BEAT_LG:0] KIDX = (BEAT_LG+1)'(k);
    logic keep;
    assign keep = left_i ? (KIDX < r_amt) : ((KIDX >= r_amt) && (KIDX < r_end));
    assign data_o[k*ELEM_W +: ELEM_W] = keep ? stg[BEAT_LG][k*ELEM_W +: ELEM_W] : '0;
  end
endmodule

// File: rtl/bfly_beat_path.sv
module bfly_beat_path
  import bfly_pkg::*;
#(
  parameter int unsigned NUM_ELEM   = 128,
  parameter int unsigned ELEM_W     = 16,
  parameter int unsigned BEAT_ELEMS = 16,
  localparam int unsigned DP_W      = ELEM_W * BEAT_ELEMS,
  localparam int unsigned NUM_BEATS = NUM_ELEM / BEAT_ELEMS,
  localparam int unsigned BEAT_AW   = $clog2(NUM_BEATS),
  localparam int unsigned LG_W      = $clog2(NUM_ELEM),
  localparam int unsigned BEAT_LG   = $clog2(BEAT_ELEMS),
  localparam int unsigned QW        = BEAT_AW + 1
)(
  input  logic [BEAT_AW-1:0] cnt_i,
  input  bfly_case_e         case_i,
  input  logic [LG_W-1:0]    lg_i,
  input  logic [DP_W-1:0]    src_i,
  output logic [BEAT_AW-1:0] rd_beat_o,
  output logic [DP_W-1:0]    dst_o
);
  logic               is_left, is_sub, hit;
  logic [QW-1:0]      q, b;
  logic [BEAT_AW-1:0] src_b;
  logic [DP_W-1:0]    lane;

  bfly_lane_shift #(.ELEM_W(ELEM_W), .BEAT_ELEMS(BEAT_ELEMS)) u_lane (
    .data_i (src_i),
    .left_i (is_left),
    .lg_i   (lg_i[BEAT_LG-1:0]),
    .data_o (lane)
  );

  always_comb begin
    is_left = case_i inside {CASE_L_SUB, CASE_L_ONE, CASE_L_MULTI};
    is_sub  = case_i inside {CASE_L_SUB, CASE_R_SUB};
    b       = {1'b0, cnt_i};
    // distance in whole beats for beat-aligned radices
    q       = is_sub ? '0 : QW'(QW'(1) << (lg_i - LG_W'(BEAT_LG)));
    if (is_sub) begin
      hit   = (cnt_i == '0);
      src_b = '0;
    end else if (is_left) begin
      hit   = (b < q);
      src_b = cnt_i + q[BEAT_AW-1:0];
    end else begin
      hit   = (b >= q) && (b < (q << 1));
      src_b = cnt_i - q[BEAT_AW-1:0];
    end
    rd_beat_o = hit ? src_b : cnt_i;
    dst_o     = !hit ? '0 : (is_sub ? lane : src_i);
  end
endmodule

// File: rtl/bfly_perm_unit.sv
module bfly_perm_unit
  import bfly_pkg::*;
#(
  parameter int unsigned NUM_ELEM   = 128,
  parameter int unsigned ELEM_W     = 16,
  parameter int unsigned DP_W       = 256,
  localparam int unsigned BEAT_ELEMS = DP_W / ELEM_W,
  localparam int unsigned NUM_BEATS  = NUM_ELEM / BEAT_ELEMS,
  localparam int unsigned BEAT_AW    = $clog2(NUM_BEATS),
  localparam int unsigned RADIX_W    = $clog2(NUM_ELEM) + 1
)(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               dir_i,
  input  logic [RADIX_W-1:0] radix_i,
  output logic [BEAT_AW-1:0] rd_beat_o,
  input  logic [DP_W-1:0]    rd_data_i,
  output logic               wr_en_o,
  output logic [BEAT_AW-1:0] wr_beat_o,
  output logic [DP_W-1:0]    wr_data_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o
);
  localparam int unsigned LG_W = $clog2(NUM_ELEM);

  logic               dec_ok;
  bfly_case_e         dec_case, case_q;
  logic [LG_W-1:0]    dec_lg, lg_q;
  logic               run, accept;
  logic [BEAT_AW-1:0] cnt;
  logic [DP_W-1:0]    beat_data;

  bfly_decode #(.NUM_ELEM(NUM_ELEM), .BEAT_ELEMS(BEAT_ELEMS)) u_dec (
    .radix_i (radix_i),
    .dir_i   (dir_i),
    .ok_o    (dec_ok),
    .case_o  (dec_case),
    .lg_o    (dec_lg)
  );

  bfly_seq #(.NUM_BEATS(NUM_BEATS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ok_i    (dec_ok),
    .busy_o  (busy_o),
    .run_o   (run),
    .cnt_o   (cnt),
    .done_o  (done_o),
    .err_o   (err_o)
  );

  assign accept = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      case_q <= CASE_L_SUB;
      lg_q   <= '0;
    end else if (accept && dec_ok) begin
      case_q <= dec_case;
      lg_q   <= dec_lg;
    end
  end

  bfly_beat_path #(.NUM_ELEM(NUM_ELEM), .ELEM_W(ELEM_W), .BEAT_ELEMS(BEAT_ELEMS)) u_path (
    .cnt_i     (cnt),
    .case_i    (case_q),
    .lg_i      (lg_q),
    .src_i     (rd_data_i),
    .rd_beat_o (rd_beat_o),
    .dst_o     (beat_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o   <= 1'b0;
      wr_beat_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= run;
      if (run) begin
        wr_beat_o <= cnt;
        wr_data_o <= beat_data;
      end
    end
  end
endmodule

// File: rtl/bfly_perm_chk.sv
module bfly_perm_chk #(
  parameter int unsigned BEAT_AW = 3
)(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_o,
  input logic [BEAT_AW-1:0] wr_beat_o,
  input logic               busy_o,
  input logic               done_o,
  input logic               err_o
);
  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!wr_en_o && !busy_o && !done_o && !err_o);
    end
  end

  // R5
  first_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> wr_beat_o == '0);

  // R5
  beat_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && $past(wr_en_o) |-> wr_beat_o == BEAT_AW'($past(wr_beat_o) + BEAT_AW'(1)));

  // R5
  write_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);

  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !wr_en_o);

  // R6
  done_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> $past(wr_en_o) && $past(wr_beat_o) == '1);

  // R7
  err_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && !$past(busy_o));
endmodule

bind bfly_perm_unit bfly_perm_chk #(.BEAT_AW(BEAT_AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_o   (wr_en_o),
  .wr_beat_o (wr_beat_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/sim_bfly_perm_unit.sv
`timescale 1ns/1ps
module sim_bfly_perm_unit;
  localparam int NUM_ELEM  = 128;
  localparam int ELEM_W    = 16;
  localparam int DP_W      = 256;
  localparam int BEAT_EL   = DP_W / ELEM_W;
  localparam int NUM_BEATS = NUM_ELEM / BEAT_EL;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start, dir;
  logic [7:0]     radix;
  logic [2:0]     rd_beat;
  logic [DP_W-1:0] rd_data;
  logic           wr_en;
  logic [2:0]     wr_beat;
  logic [DP_W-1:0] wr_data;
  logic           busy, done, err;

  logic [DP_W-1:0]   src_mem [NUM_BEATS];
  logic [ELEM_W-1:0] exp_el  [NUM_ELEM];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign rd_data = src_mem[rd_beat];

  bfly_perm_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .dir_i(dir), .radix_i(radix),
    .rd_beat_o(rd_beat), .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_beat_o(wr_beat),
    .wr_data_o(wr_data), .busy_o(busy), .done_o(done), .err_o(err)
  );

  task automatic check(input string req, input string what,
                       input logic [DP_W-1:0] act, input logic [DP_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [ELEM_W-1:0] src_el(input int j);
    return src_mem[j / BEAT_EL][(j % BEAT_EL)*ELEM_W +: ELEM_W];
  endfunction

  task automatic fill_src(input int seed);
    for (int j = 0; j < NUM_ELEM; j++)
      src_mem[j / BEAT_EL][(j % BEAT_EL)*ELEM_W +: ELEM_W] = 16'(16'h1000 + j * 37 + seed * 911 + 1);
  endtask

  // index-mapping reference model
  task automatic build_ref(input logic d, input int r);
    for (int i = 0; i < NUM_ELEM; i++) exp_el[i] = '0;
    for (int i = 0; i < r; i++) begin
      if (!d) exp_el[i]     = src_el(i + r);
      else    exp_el[i + r] = src_el(i);
    end
  endtask

  function automatic logic [DP_W-1:0] exp_beat(input int k);
    logic [DP_W-1:0] v;
    for (int e = 0; e < BEAT_EL; e++) v[e*ELEM_W +: ELEM_W] = exp_el[k*BEAT_EL + e];
    return v;
  endfunction

  // disturb: hold start, flip dir and scramble radix while busy (R8, R9)
  task automatic run_op(input logic d, input int r, input bit disturb);
    string rq;
    rq = d ? "R3/R4" : "R2/R4";
    build_ref(d, r);
    @(negedge clk);
    start = 1'b1; dir = d; radix = 8'(r);
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin start = 1'b1; dir = ~d; radix = 8'd3; end
    check("R6", "busy at first cycle", DP_W'(busy), DP_W'(1));
    check("R5", "no write before first beat", DP_W'(wr_en), DP_W'(0));
    for (int k = 0; k < NUM_BEATS; k++) begin
      @(negedge clk);
      if (disturb && k == NUM_BEATS - 1) begin start = 1'b0; radix = 8'(r); dir = d; end
      check("R5", "write strobe", DP_W'(wr_en), DP_W'(1));
      check("R5", "write beat order", DP_W'(wr_beat), DP_W'(k));
      check(disturb ? "R9" : rq, "write data", wr_data, exp_beat(k));
      check("R6", "busy during writes", DP_W'({busy, done}), DP_W'(2'b10));
    end
    @(negedge clk);
    check("R6", "done pulse after last beat", DP_W'({done, busy, wr_en}), DP_W'(3'b100));
    check("R7", "no error on valid radix", DP_W'(err), DP_W'(0));
    @(negedge clk);
    check(disturb ? "R8" : "R6", "idle after done", DP_W'({done, busy, wr_en}), DP_W'(3'b000));
    @(negedge clk);
    check("R8", "no restart", DP_W'({busy, wr_en}), DP_W'(2'b00));
  endtask

  task automatic bad_op(input logic d, input int r);
    @(negedge clk);
    start = 1'b1; dir = d; radix = 8'(r);
    @(negedge clk);
    start = 1'b0;
    check("R7", $sformatf("reject radix %0d", r), DP_W'({done, err, busy, wr_en}), DP_W'(4'b1100));
    @(negedge clk);
    check("R7", "error is one pulse, no write", DP_W'({done, err, busy, wr_en}), DP_W'(4'b0000));
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; dir = 1'b0; radix = '0;
    fill_src(0);
    repeat (3) @(negedge clk);
    check("R1", "outputs in reset", DP_W'({wr_en, busy, done, err}), DP_W'(0));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "outputs after reset", DP_W'({wr_en, busy, done, err}), DP_W'(0));

    for (int lg = 0; lg < 7; lg++) begin
      run_op(1'b0, 1 << lg, 1'b0);
      run_op(1'b1, 1 << lg, 1'b0);
    end
    fill_src(5);
    run_op(1'b0, 4, 1'b1);
    run_op(1'b1, 32, 1'b1);
    run_op(1'b1, 1, 1'b1);
    run_op(1'b0, 64, 1'b1);

    bad_op(1'b0, 0);
    bad_op(1'b1, 3);
    bad_op(1'b0, 96);
    bad_op(1'b1, 128);
    bad_op(1'b0, 255);

    fill_src(9);
    run_op(1'b1, 8, 1'b0);
    run_op(1'b0, 16, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule